// File: doc/BRIEF.md
# Multicast RTP Audio Frame Transmitter

This block builds one complete Ethernet frame each time a start pulse is accepted and streams it byte by byte onto an 8-bit gigabit media-independent transmit interface. The frame nests an IPv4 header, a UDP header and an RTP header around a fixed-size block of audio samples for one channel. The destination is a multicast group, so the destination MAC address is formed from the group IP address rather than configured.

Address, port and synchronisation-source settings come in as static inputs. The block keeps one RTP sequence number and one RTP timestamp per channel. It computes the IPv4 header checksum when it accepts the start, so the checksum is ready before the header goes out. While the header is being sent it reads the channel's samples from an external buffer through a byte-wide read port with one cycle of latency. It appends the Ethernet frame check sequence and then keeps the line idle for a minimum gap before it takes the next request.

Top module: `rtp_frame_tx`

## Requirements
- R1: A start seen at a clock edge while the block is idle raises gmii_tx_en after the following edge. The frame opens with seven bytes of 0x55 and one byte of 0xD5, and gmii_tx_en stays high without a break from the first preamble byte through the last check-sequence byte.
- R2: gmii_tx_en is high for exactly 8 + 54 + PAY_BYTES + 4 cycles per frame, where PAY_BYTES = SAMPLES * BYTES_PER_SAMPLE (968 by default).
- R3: After the preamble, the first six bytes are 0x01, 0x00, 0x5E, then the low 23 bits of dst_ip with bit 23 forced to zero, sent most significant first. Next come the six bytes of src_mac, most significant first, then the type 0x08 0x00.
- R4: The IPv4 header, in wire order, is 0x45, 0x00, total length 40 + PAY_BYTES, identification 0, flags and fragment 0x4000, TTL parameter, protocol 17, header checksum, src_ip, dst_ip. All multi-byte fields are big-endian. The ones-complement sum of the ten 16-bit header words, checksum included, is 0xFFFF.
- R5: The UDP header is src_port, dst_port, length 20 + PAY_BYTES and a checksum of zero, all big-endian.
- R6: The RTP header starts with 0x80, then {0, PT}. It then carries the sequence number (16 bits), the timestamp (32 bits) and a synchronisation source equal to ssrc_base + chan_id (32 bits), all big-endian.
- R7: After reset every channel's sequence number and timestamp start at 0. Each accepted frame for a channel raises that channel's sequence number by 1 and its timestamp by SAMPLES. Other channels are unaffected.
- R8: Payload byte k (k = 0 .. PAY_BYTES-1) equals the rd_data value returned one cycle after rd_en was high with rd_addr = k and rd_chan = the frame's channel. rd_en is high only while gmii_tx_en is high.
- R9: The last four bytes are the frame check sequence: the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, final inversion). It covers the bytes from the destination MAC through the last payload byte and is sent low byte first.
- R10: A start that arrives while a frame or its gap is in progress is ignored: it produces no frame and changes no sequence number. At least 12 cycles with gmii_tx_en low separate the end of one frame from the start of the next.
- R11: During and after reset gmii_tx_en and rd_en are low, and gmii_txd is 0x00 whenever gmii_tx_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one frame |
| chan_id | input | CH_W | Channel for the requested frame |
| src_mac | input | 48 | Source MAC address |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Multicast group IPv4 address |
| src_port | input | 16 | UDP source port |
| dst_port | input | 16 | UDP destination port |
| ssrc_base | input | 32 | Base synchronisation source, channel added |
| rd_en | output | 1 | Sample buffer read strobe |
| rd_chan | output | CH_W | Channel being read |
| rd_addr | output | ADDR_W | Payload byte address |
| rd_data | input | 8 | Byte read, valid one cycle after rd_en |
| gmii_txd | output | 8 | Transmit byte |
| gmii_tx_en | output | 1 | Transmit enable |

## Verification
Frames are requested on an interleaved channel order (0, 1, 0, 2, 3). This separates the per-channel sequence and timestamp counters from a single shared counter. The group addresses include one with bit 23 set, which shows whether that bit is cleared in the destination MAC, and one with small values, which catches byte-order slips. The payload pattern depends on both channel and address, so a wrong channel select or an off-by-one read latency changes bytes. A check sequence recomputed over the captured bytes exposes any corrupted or missing byte. A start pulsed in the middle of a frame and a start held high across frame ends test the ignore rule and the idle gap.

// File: rtl/rtp_tx_pkg.sv
package rtp_tx_pkg;

    localparam int HDR_BYTES = 54;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_PAY,
        PH_FCS,
        PH_GAP
    } phase_t;

    // One byte of the reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] b);
        logic [31:0] c;
        c = crc ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rtp_ipv4_csum.sv
module rtp_ipv4_csum #(
    parameter logic [7:0] TTL    = 8'd32,
    parameter int         IP_LEN = 1008
) (
    input  logic [31:0] src_ip,
    input  logic [31:0] dst_ip,
    output logic [15:0] csum
);
    logic [31:0] sum;
    logic [31:0] fold1;
    logic [31:0] fold2;

    always_comb begin
        sum = 32'h4500 + 32'(IP_LEN & 16'hFFFF) + 32'h4000 + {16'd0, TTL, 8'd17}
            + {16'd0, src_ip[31:16]} + {16'd0, src_ip[15:0]}
            + {16'd0, dst_ip[31:16]} + {16'd0, dst_ip[15:0]};
        fold1 = {16'd0, sum[15:0]} + {16'd0, sum[31:16]};
        fold2 = {16'd0, fold1[15:0]} + {16'd0, fold1[31:16]};
        csum  = ~fold2[15:0];
    end
endmodule

// File: rtl/rtp_crc32.sv
module rtp_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    import rtp_tx_pkg::*;

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear)   crc_d = 32'hFFFFFFFF;
        else if (en) crc_d = crc32_step(crc_q, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= 32'hFFFFFFFF;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/rtp_hdr_mux.sv
module rtp_hdr_mux #(
    parameter int         CH_W      = 2,
    parameter int         PAY_BYTES = 968,
    parameter logic [6:0] PT        = 7'd96,
    parameter logic [7:0] TTL       = 8'd32
) (
    input  logic [47:0]     src_mac,
    input  logic [31:0]     src_ip,
    input  logic [31:0]     dst_ip,
    input  logic [15:0]     src_port,
    input  logic [15:0]     dst_port,
    input  logic [31:0]     ssrc_base,
    input  logic [CH_W-1:0] chan,
    input  logic [15:0]     seq,
    input  logic [31:0]     ts,
    input  logic [15:0]     csum,
    input  logic [5:0]      idx,
    output logic [7:0]      hbyte
);
    import rtp_tx_pkg::*;

    localparam logic [15:0] IP_LEN  = 16'(40 + PAY_BYTES);
    localparam logic [15:0] UDP_LEN = 16'(20 + PAY_BYTES);

    logic [HDR_BYTES*8-1:0] hdr;

    always_comb begin
        hdr = {8'h01, 8'h00, 8'h5E, 1'b0, dst_ip[22:0], src_mac, 16'h0800,
               8'h45, 8'h00, IP_LEN, 16'h0000, 16'h4000, TTL, 8'd17, csum, src_ip, dst_ip,
               src_port, dst_port, UDP_LEN, 16'h0000,
               8'h80, 1'b0, PT, seq, ts, ssrc_base + 32'(chan)};
        hbyte = 8'h00;
        if (int'(idx) < HDR_BYTES) hbyte = hdr[(HDR_BYTES-1-int'(idx))*8 +: 8];
    end
endmodule

// File: rtl/rtp_frame_tx.sv
module rtp_frame_tx #(
    parameter int         NCH              = 4,
    parameter int         SAMPLES          = 242,
    parameter int         BYTES_PER_SAMPLE = 4,
    parameter int         IFG              = 12,
    parameter logic [6:0] PT               = 7'd96,
    parameter logic [7:0] TTL              = 8'd32,
    localparam int        CH_W             = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int        PAY_BYTES        = SAMPLES * BYTES_PER_SAMPLE,
    localparam int        ADDR_W           = $clog2(PAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CH_W-1:0]   chan_id,
    input  logic [47:0]       src_mac,
    input  logic [31:0]       src_ip,
    input  logic [31:0]       dst_ip,
    input  logic [15:0]       src_port,
    input  logic [15:0]       dst_port,
    input  logic [31:0]       ssrc_base,
    output logic              rd_en,
    output logic [CH_W-1:0]   rd_chan,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic [7:0]        gmii_txd,
    output logic              gmii_tx_en
);
    import rtp_tx_pkg::*;

    localparam int CNT_W     = $clog2(PAY_BYTES + 64);
    localparam int FRAME_LEN = 8 + HDR_BYTES + PAY_BYTES + 4;
    localparam logic [CNT_W-1:0] C_PRE_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] C_PAY_LAST = CNT_W'(PAY_BYTES - 1);
    localparam logic [CNT_W-1:0] C_FCS_LAST = CNT_W'(3);
    localparam logic [CNT_W-1:0] C_GAP_LAST = CNT_W'(IFG - 1);

    typedef struct packed {
        phase_t                 phase;
        logic [CNT_W-1:0]       cnt;
        logic [CH_W-1:0]        chan;
        logic [15:0]            seq_cur;
        logic [31:0]            ts_cur;
        logic [15:0]            csum;
        logic [NCH-1:0][15:0]   seq_tab;
        logic [NCH-1:0][31:0]   ts_tab;
        logic [7:0]             txd;
        logic                   txen;
    } state_t;

    state_t      s_d, s_q;
    logic [15:0] csum_w;
    logic [7:0]  hbyte;
    logic [31:0] crc_w;
    logic [31:0] fcs_w;
    logic        crc_clr, crc_en;
    logic [7:0]  crc_din;

    rtp_ipv4_csum #(.TTL(TTL), .IP_LEN(40 + PAY_BYTES)) u_csum (
        .src_ip(src_ip), .dst_ip(dst_ip), .csum(csum_w)
    );

    rtp_hdr_mux #(.CH_W(CH_W), .PAY_BYTES(PAY_BYTES), .PT(PT), .TTL(TTL)) u_hdr (
        .src_mac(src_mac), .src_ip(src_ip), .dst_ip(dst_ip),
        .src_port(src_port), .dst_port(dst_port), .ssrc_base(ssrc_base),
        .chan(s_q.chan), .seq(s_q.seq_cur), .ts(s_q.ts_cur), .csum(s_q.csum),
        .idx(s_q.cnt[5:0]), .hbyte(hbyte)
    );

    rtp_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en), .din(crc_din), .crc(crc_w)
    );

    assign fcs_w = ~crc_w;

    always_comb begin
        s_d     = s_q;
        s_d.txd  = 8'h00;
        s_d.txen = 1'b0;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        crc_din = 8'h00;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase   = PH_PRE;
                    s_d.cnt     = '0;
                    s_d.chan    = chan_id;
                    s_d.seq_cur = s_q.seq_tab[chan_id];
                    s_d.ts_cur  = s_q.ts_tab[chan_id];
                    s_d.csum    = csum_w;
                    s_d.seq_tab[chan_id] = s_q.seq_tab[chan_id] + 16'd1;
                    s_d.ts_tab[chan_id]  = s_q.ts_tab[chan_id] + 32'(SAMPLES);
                    crc_clr     = 1'b1;
                end
            end
            PH_PRE: begin
                s_d.txen = 1'b1;
                s_d.txd  = (s_q.cnt == C_PRE_LAST) ? 8'hD5 : 8'h55;
                if (s_q.cnt == C_PRE_LAST) begin
                    s_d.phase = PH_HDR;
                    s_d.cnt   = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_HDR: begin
                s_d.txen = 1'b1;
                s_d.txd  = hbyte;
                crc_en   = 1'b1;
                crc_din  = hbyte;
                if (s_q.cnt == C_HDR_LAST) begin
                    s_d.phase = PH_PAY;
                    s_d.cnt   = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_PAY: begin
                s_d.txen = 1'b1;
                s_d.txd  = rd_data;
                crc_en   = 1'b1;
                crc_din  = rd_data;
                if (s_q.cnt == C_PAY_LAST) begin
                    s_d.phase = PH_FCS;
                    s_d.cnt   = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_FCS: begin
                s_d.txen = 1'b1;
                s_d.txd  = fcs_w[8*s_q.cnt[1:0] +: 8];
                if (s_q.cnt == C_FCS_LAST) begin
                    s_d.phase = PH_GAP;
                    s_d.cnt   = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_GAP: begin
                if (s_q.cnt == C_GAP_LAST) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    // Payload read is issued one cycle ahead of the byte it feeds.
    assign rd_en   = ((s_q.phase == PH_HDR) && (s_q.cnt == C_HDR_LAST)) ||
                     ((s_q.phase == PH_PAY) && (s_q.cnt != C_PAY_LAST));
    assign rd_addr = (s_q.phase == PH_PAY) ? ADDR_W'(s_q.cnt + 1'b1) : '0;
    assign rd_chan = s_q.chan;
    assign gmii_txd   = s_q.txd;
    assign gmii_tx_en = s_q.txen;

    // Observation counters for the line-level properties.
    logic [15:0] len_q;
    logic [7:0]  idle_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            idle_q <= 8'hFF;
        end else begin
            len_q  <= gmii_tx_en ? len_q + 16'd1 : 16'd0;
            idle_q <= gmii_tx_en ? 8'd0 : ((idle_q == 8'hFF) ? idle_q : idle_q + 8'd1);
        end
    end

    a_r1_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmii_tx_en) |-> gmii_txd == 8'h55);
    a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gmii_tx_en) |-> len_q == 16'(FRAME_LEN));
    a_r10_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmii_tx_en) |-> idle_q >= 8'(IFG));
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !gmii_tx_en |-> gmii_txd == 8'h00);
    a_r8_read_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (gmii_tx_en && int'(rd_addr) < PAY_BYTES));
endmodule

// File: tb/tb_rtp_frame_tx.sv
module tb_rtp_frame_tx;
    localparam int NCH = 4, SAMPLES = 242, BPS = 4;
    localparam int P = SAMPLES * BPS;
    localparam int FLEN = 8 + 54 + P + 4;
    localparam logic [47:0] SMAC = 48'h0212_3456_789A;
    localparam logic [31:0] SIP = 32'hC0A8_0A05, SSRC = 32'h1000_0000;
    localparam logic [15:0] SPORT = 16'd5004, DPORT = 16'd5006;

    localparam int NV = 5;
    localparam int          V_CH  [NV] = '{0, 1, 0, 2, 3};
    localparam logic [31:0] V_IP  [NV] = '{32'hEFFF_FFFF, 32'hE000_0001, 32'hE080_1234, 32'hEF01_0203, 32'hE17F_00FE};
    localparam int          V_SEQ [NV] = '{0, 0, 1, 0, 0};

    logic clk = 0, rst_n = 0, start = 0;
    logic [1:0] chan_id = 0;
    logic [31:0] dst_ip = 32'hE000_0001;
    logic rd_en, gmii_tx_en;
    logic [1:0] rd_chan;
    logic [9:0] rd_addr;
    logic [7:0] rd_data = 0, gmii_txd;

    int checks = 0, errors = 0;
    logic [7:0] fb [0:2047];
    int fn, lat;

    always #4 clk = ~clk;

    rtp_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_id(chan_id),
        .src_mac(SMAC), .src_ip(SIP), .dst_ip(dst_ip), .src_port(SPORT), .dst_port(DPORT),
        .ssrc_base(SSRC), .rd_en(rd_en), .rd_chan(rd_chan), .rd_addr(rd_addr),
        .rd_data(rd_data), .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en)
    );

    function automatic logic [7:0] pat(int ch, int a);
        return 8'((ch * 53 + a * 7 + (a >> 3)) & 255);
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= pat(int'(rd_chan), int'(rd_addr));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_sim();
    end

    function automatic logic [15:0] be16(int o); return {fb[o], fb[o+1]}; endfunction
    function automatic logic [31:0] be32(int o); return {fb[o], fb[o+1], fb[o+2], fb[o+3]}; endfunction

    // Collect one frame; optional start injected after mid_at bytes.
    task automatic capture(input int mid_at, input int mid_ch);
        int w = 0;
        fn = 0;
        while (!gmii_tx_en && w < 100) begin @(negedge clk); w++; end
        while (gmii_tx_en && fn < 2048) begin
            fb[fn] = gmii_txd; fn++;
            if (fn == mid_at) begin start = 1; chan_id = 2'(mid_ch); end
            else start = 0;
            @(negedge clk);
        end
        start = 0;
    endtask

    task automatic run_frame(input int ch, input int mid_at, input int mid_ch);
        start = 1; chan_id = 2'(ch);
        @(negedge clk); start = 0;
        lat = 0;
        while (!gmii_tx_en && lat < 100) begin @(negedge clk); lat++; end
        capture(mid_at, mid_ch);
    endtask

    task automatic check_frame(input int ch, input logic [31:0] dip, input int seq);
        int o = 8, bad = 0;
        logic [31:0] c = 32'hFFFFFFFF, sum = 0;
        chk(fn == FLEN, "R2 frame length", fn, FLEN);
        for (int i = 0; i < 7; i++) if (fb[i] != 8'h55) bad++;
        chk(bad == 0 && fb[7] == 8'hD5, "R1 preamble/SFD", {24'd0, fb[7]}, 8'hD5);
        chk({fb[o],fb[o+1],fb[o+2],fb[o+3],fb[o+4],fb[o+5]} == {24'h01005E, 1'b0, dip[22:0]},
            "R3 dest MAC", {be32(o), be16(o+4)}, {24'h01005E, 1'b0, dip[22:0]});
        chk({be32(o+6), be16(o+10), be16(o+12)} == {SMAC, 16'h0800}, "R3 src MAC/type",
            {be32(o+6), be16(o+10), be16(o+12)}, {SMAC, 16'h0800});
        o = 22;
        chk({be32(o), be32(o+4), be16(o+8)} == {16'h4500, 16'(40+P), 32'h0000_4000, 8'd32, 8'd17},
            "R4 IP fixed fields", {be32(o), be32(o+4), be16(o+8)}, {16'h4500, 16'(40+P), 32'h4000, 16'h2011});
        chk(be32(o+12) == SIP && be32(o+16) == dip, "R4 IP addresses", be32(o+16), dip);
        for (int i = 0; i < 10; i++) sum += {16'd0, be16(o + 2*i)};
        sum = {16'd0, sum[15:0]} + {16'd0, sum[31:16]};
        sum = {16'd0, sum[15:0]} + {16'd0, sum[31:16]};
        chk(sum[15:0] == 16'hFFFF, "R4 IP checksum", sum[15:0], 16'hFFFF);
        o = 42;
        chk({be32(o), be32(o+4)} == {SPORT, DPORT, 16'(20+P), 16'h0000}, "R5 UDP header",
            {be32(o), be32(o+4)}, {SPORT, DPORT, 16'(20+P), 16'h0000});
        o = 50;
        chk(fb[o] == 8'h80 && fb[o+1] == 8'd96 && be32(o+8) == SSRC + 32'(ch), "R6 RTP header",
            be32(o+8), SSRC + 32'(ch));
        chk(be16(o+2) == 16'(seq), "R7 RTP sequence", be16(o+2), seq);
        chk(be32(o+4) == 32'(seq * SAMPLES), "R7 RTP timestamp", be32(o+4), seq * SAMPLES);
        bad = 0;
        for (int k = 0; k < P; k++) if (fb[62+k] != pat(ch, k)) bad++;
        chk(bad == 0, "R8 payload bytes", bad, 0);
        for (int i = 8; i < 62 + P; i++) begin
            c ^= {24'd0, fb[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        chk({fb[65+P], fb[64+P], fb[63+P], fb[62+P]} == c, "R9 FCS",
            {fb[65+P], fb[64+P], fb[63+P], fb[62+P]}, c);
    endtask

    initial begin
        int gap, seen;
        repeat (3) @(negedge clk);
        chk(!gmii_tx_en && gmii_txd == 0 && !rd_en, "R11 in reset", {gmii_tx_en, gmii_txd}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!gmii_tx_en && gmii_txd == 0 && !rd_en, "R11 after reset", {gmii_tx_en, gmii_txd}, 0);

        for (int v = 0; v < NV; v++) begin
            dst_ip = V_IP[v];
            run_frame(V_CH[v], -1, 0);
            chk(lat == 1, "R1 start latency", lat, 1);
            check_frame(V_CH[v], V_IP[v], V_SEQ[v]);
            repeat (20) @(negedge clk);
        end

        // Start during a frame must be ignored (R10).
        dst_ip = 32'hE000_0001;
        run_frame(0, 300, 1);
        check_frame(0, dst_ip, 2);
        seen = 0;
        repeat (40) begin @(negedge clk); if (gmii_tx_en) seen++; end
        chk(seen == 0, "R10 busy start no frame", seen, 0);
        run_frame(1, -1, 0);
        check_frame(1, dst_ip, 1);
        repeat (20) @(negedge clk);

        // Start held high across frame end: gap and back-to-back (R10).
        start = 1; chan_id = 2'd2;
        capture(-1, 0);
        start = 1;
        check_frame(2, dst_ip, 1);
        gap = 1;
        while (!gmii_tx_en && gap < 100) begin @(negedge clk); gap++; end
        start = 0;
        chk(gap >= 12 && gap < 100, "R10 idle gap", gap, 12);
        capture(-1, 0);
        check_frame(2, dst_ip, 2);
        repeat (20) @(negedge clk);
        chk(!gmii_tx_en && gmii_txd == 0, "R11 idle line", gmii_txd, 0);
        finish_sim();
    end
endmodule